// File: doc/BRIEF.md
# Accuracy-Aware Memory Request Scheduler

This block picks which request a DRAM controller serves next. It holds a small buffer of pending read requests. Each request is either a demand or a prefetch and comes from one of several cores. Every request names a bank, a row and a column. On each DRAM bus cycle, marked by a one-cycle tick, the block chooses the single best entry and reports its slot number with a grant strobe. The granted slot is freed on the next clock.

The choice depends on how useful each core's prefetches have been. Each core supplies one bit that says whether its measured prefetch accuracy is at or above the promotion level (85 percent). The requests are ranked on four keys, most important first:

- **Critical.** The request is a demand, or it is a prefetch from a core whose accuracy bit is set.
- **Row hit.** The request targets the row now open in its bank.
- **Urgent.** The request is a demand from a core whose accuracy bit is clear.
- **Age.** The oldest request wins.

Prefetches from inaccurate cores therefore drop to the bottom of the ranking. When they have high accuracy, prefetches compete equally with demands and take part in row-hit batching.

A demand that arrives for the same line as a buffered prefetch does not use a new slot. Instead it turns that prefetch into a demand, so the request is promoted.

Top module: `acc_aware_sched`

## Requirements
- R1: After reset the buffer is empty, and `grant_valid` stays low even when `bus_tick` is high.
- R2: An accepted new request takes the lowest-numbered free slot, and at most one slot is filled per clock.
- R3: No grant is issued in a cycle where `bus_tick` is low or the buffer holds no valid entry. Entries are kept unchanged apart from ageing.
- R4: A critical entry always beats a non-critical one. An entry is critical if it is a demand (`enq_is_pref` = 0 at entry) or a prefetch whose core has its `acc_ok[core]` bit set to 1. This holds whatever the row-hit status and age of the two entries.
- R5: Among entries that are equal on the critical key, a row hit beats a miss. A row hit means `open_vld[bank]` = 1 and `open_row[bank*ROW_W +: ROW_W]` equals the entry's row. A bank with `open_vld` = 0 produces no hit.
- R6: Among entries equal on the critical and row-hit keys, an urgent entry beats a non-urgent one. An urgent entry is a demand from a core with `acc_ok` = 0.
- R7: Among entries equal on all three flag keys, the entry with the largest age wins. Age is the number of clocks since the entry was accepted.
- R8: A granted slot is invalid from the next clock onward, and it is never granted twice for one acceptance.
- R9: A demand whose bank, row and column match a valid prefetch entry clears that entry's prefetch flag. It fills no new slot, and the merged entry keeps its age and core.
- R10: A request that arrives while every slot is valid is discarded, unless it is a demand that merges under R9.
- R11: Age saturates at 2^AGE_W-1. When entries tie on all keys including age, the lowest slot number wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | A new request is offered this clock |
| enq_is_pref | input | 1 | 1 = prefetch, 0 = demand |
| enq_core | input | CORE_W | Requesting core |
| enq_bank | input | BANK_W | Target bank |
| enq_row | input | ROW_W | Target row |
| enq_col | input | COL_W | Target column (line within row) |
| acc_ok | input | NUM_CORE | Per core: 1 when prefetch accuracy is at or above the promotion level |
| open_vld | input | NUM_BANK | Per bank: a row is open |
| open_row | input | NUM_BANK*ROW_W | Open row of each bank, bank b at bits b*ROW_W |
| bus_tick | input | 1 | A scheduling decision is taken this clock |
| grant_valid | output | 1 | An entry is granted this clock |
| grant_idx | output | IDX_W | Slot number of the granted entry |

## Verification
The hardest cases to reach involve several entries that differ in only one priority key while all higher keys are equal. Reaching them requires filling the buffer with `bus_tick` held low and then flipping `acc_ok` and the open rows before the first tick. The saturation tie in R11 needs slot 0 to be refilled behind older entries, followed by a long wait with no ticks. A full buffer that receives one more request is also built from a series of ticks held low. A long random phase uses only two banks, rows and columns so that row hits and merges are frequent. Every clock is compared against a behavioural model of the buffer.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int ROW_W   = 14;
    localparam int COL_W   = 7;
    localparam int AGE_W   = 8;
    localparam int AGE_MAX = (1 << AGE_W) - 1;

    typedef logic [AGE_W-1:0] age_t;

    // Ranking key: a larger unsigned value wins. valid sits on top so that empty slots always lose.
    typedef struct packed {
        logic valid;
        logic crit;
        logic rowhit;
        logic urgent;
        age_t age;
    } prio_key_t;

    function automatic age_t age_step(input age_t a);
        return (a == age_t'(AGE_MAX)) ? a : a + 1'b1;
    endfunction

endpackage

// File: rtl/sched_prio_key.sv
module sched_prio_key
    import sched_pkg::*;
#(
    parameter int NUM_CORE = 4,
    parameter int NUM_BANK = 8,
    parameter int ROW_W    = sched_pkg::ROW_W,
    localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
    localparam int BANK_W  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1
) (
    input  logic                      valid,
    input  logic                      is_pref,
    input  logic [CORE_W-1:0]         core,
    input  logic [BANK_W-1:0]         bank,
    input  logic [ROW_W-1:0]          row,
    input  age_t                      age,
    input  logic [NUM_CORE-1:0]       acc_ok,
    input  logic [NUM_BANK-1:0]       open_vld,
    input  logic [NUM_BANK*ROW_W-1:0] open_row,
    output prio_key_t                 key
);

    logic             core_ok;
    logic [ROW_W-1:0] bank_row;

    always_comb begin
        core_ok    = acc_ok[core];
        bank_row   = open_row[int'(bank)*ROW_W +: ROW_W];
        key.valid  = valid;
        key.crit   = !is_pref || core_ok;
        key.rowhit = open_vld[bank] && (bank_row == row);
        key.urgent = !is_pref && !core_ok;
        key.age    = age;
    end

endmodule

// File: rtl/sched_arb_tree.sv
module sched_arb_tree
    import sched_pkg::*;
#(
    parameter int NUM_ENT = 16,
    localparam int IDX_W  = $clog2(NUM_ENT),
    localparam int LEAVES = 1 << IDX_W,
    localparam int NODES  = 2 * LEAVES - 1
) (
    input  prio_key_t [NUM_ENT-1:0] keys,
    output logic                    win_valid,
    output logic [IDX_W-1:0]        win_idx
);

    prio_key_t        nk [NODES];
    logic [IDX_W-1:0] ni [NODES];

    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
        if (l < NUM_ENT) begin : g_used
            assign nk[LEAVES-1+l] = keys[l];
        end else begin : g_pad
            assign nk[LEAVES-1+l] = '0;
        end
        assign ni[LEAVES-1+l] = IDX_W'(l);
    end

    // Heap layout: the left child always covers the lower slot numbers, so ">=" resolves a tie toward the lower slot.
    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
        logic take_left;
        assign take_left = (nk[2*n+1] >= nk[2*n+2]);
        assign nk[n]     = take_left ? nk[2*n+1] : nk[2*n+2];
        assign ni[n]     = take_left ? ni[2*n+1] : ni[2*n+2];
    end

    assign win_valid = nk[0].valid;
    assign win_idx   = ni[0];

endmodule

// File: rtl/sched_alloc.sv
module sched_alloc #(
    parameter int NUM_ENT  = 16,
    parameter int NUM_BANK = 8,
    parameter int ROW_W    = 14,
    parameter int COL_W    = 7,
    localparam int IDX_W   = $clog2(NUM_ENT),
    localparam int BANK_W  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1
) (
    input  logic [NUM_ENT-1:0]             ent_vld,
    input  logic [NUM_ENT-1:0]             ent_pf,
    input  logic [NUM_ENT-1:0][BANK_W-1:0] ent_bank,
    input  logic [NUM_ENT-1:0][ROW_W-1:0]  ent_row,
    input  logic [NUM_ENT-1:0][COL_W-1:0]  ent_col,
    input  logic [BANK_W-1:0]              enq_bank,
    input  logic [ROW_W-1:0]               enq_row,
    input  logic [COL_W-1:0]               enq_col,
    output logic [NUM_ENT-1:0]             pf_match,
    output logic                           free_found,
    output logic [IDX_W-1:0]               free_idx
);

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_match
        assign pf_match[e] = ent_vld[e] && ent_pf[e] &&
                             (ent_bank[e] == enq_bank) &&
                             (ent_row[e]  == enq_row)  &&
                             (ent_col[e]  == enq_col);
    end

    // The loop scans from the top slot down, so the lowest free slot is written last and wins.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (!ent_vld[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/acc_aware_sched.sv
module acc_aware_sched
    import sched_pkg::*;
#(
    parameter int NUM_ENT  = 16,
    parameter int NUM_CORE = 4,
    parameter int NUM_BANK = 8,
    parameter int ROW_W    = sched_pkg::ROW_W,
    parameter int COL_W    = sched_pkg::COL_W,
    localparam int IDX_W   = $clog2(NUM_ENT),
    localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
    localparam int BANK_W  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enq_valid,
    input  logic                      enq_is_pref,
    input  logic [CORE_W-1:0]         enq_core,
    input  logic [BANK_W-1:0]         enq_bank,
    input  logic [ROW_W-1:0]          enq_row,
    input  logic [COL_W-1:0]          enq_col,
    input  logic [NUM_CORE-1:0]       acc_ok,
    input  logic [NUM_BANK-1:0]       open_vld,
    input  logic [NUM_BANK*ROW_W-1:0] open_row,
    input  logic                      bus_tick,
    output logic                      grant_valid,
    output logic [IDX_W-1:0]          grant_idx
);

    typedef struct packed {
        logic [NUM_ENT-1:0]              vld;
        logic [NUM_ENT-1:0]              pf;
        logic [NUM_ENT-1:0][CORE_W-1:0]  core;
        logic [NUM_ENT-1:0][BANK_W-1:0]  bank;
        logic [NUM_ENT-1:0][ROW_W-1:0]   row;
        logic [NUM_ENT-1:0][COL_W-1:0]   col;
        age_t [NUM_ENT-1:0]              age;
    } buf_state_t;

    buf_state_t state_d, state_q;

    logic [NUM_ENT-1:0]             ent_vld;
    logic [NUM_ENT-1:0]             ent_pf;
    logic [NUM_ENT-1:0][CORE_W-1:0] ent_core;
    age_t [NUM_ENT-1:0]             ent_age;

    assign ent_vld  = state_q.vld;
    assign ent_pf   = state_q.pf;
    assign ent_core = state_q.core;
    assign ent_age  = state_q.age;

    prio_key_t [NUM_ENT-1:0] keys;
    logic                    win_valid;
    logic [IDX_W-1:0]        win_idx;
    logic [NUM_ENT-1:0]      pf_match;
    logic                    free_found;
    logic [IDX_W-1:0]        free_idx;
    logic                    merge_hit;

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_key
        sched_prio_key #(
            .NUM_CORE (NUM_CORE),
            .NUM_BANK (NUM_BANK),
            .ROW_W    (ROW_W)
        ) u_key (
            .valid    (state_q.vld[e]),
            .is_pref  (state_q.pf[e]),
            .core     (state_q.core[e]),
            .bank     (state_q.bank[e]),
            .row      (state_q.row[e]),
            .age      (state_q.age[e]),
            .acc_ok   (acc_ok),
            .open_vld (open_vld),
            .open_row (open_row),
            .key      (keys[e])
        );
    end

    sched_arb_tree #(
        .NUM_ENT (NUM_ENT)
    ) u_tree (
        .keys      (keys),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    sched_alloc #(
        .NUM_ENT  (NUM_ENT),
        .NUM_BANK (NUM_BANK),
        .ROW_W    (ROW_W),
        .COL_W    (COL_W)
    ) u_alloc (
        .ent_vld    (state_q.vld),
        .ent_pf     (state_q.pf),
        .ent_bank   (state_q.bank),
        .ent_row    (state_q.row),
        .ent_col    (state_q.col),
        .enq_bank   (enq_bank),
        .enq_row    (enq_row),
        .enq_col    (enq_col),
        .pf_match   (pf_match),
        .free_found (free_found),
        .free_idx   (free_idx)
    );

    assign grant_valid = bus_tick && win_valid;
    assign grant_idx   = win_idx;
    assign merge_hit   = enq_valid && !enq_is_pref && (|pf_match);

    always_comb begin
        state_d = state_q;

        for (int i = 0; i < NUM_ENT; i++) begin
            if (state_q.vld[i]) begin
                state_d.age[i] = age_step(state_q.age[i]);
            end
        end

        if (grant_valid) begin
            state_d.vld[win_idx] = 1'b0;
        end

        if (merge_hit) begin
            state_d.pf = state_q.pf & ~pf_match;
        end else if (enq_valid && free_found) begin
            state_d.vld[free_idx]  = 1'b1;
            state_d.pf[free_idx]   = enq_is_pref;
            state_d.core[free_idx] = enq_core;
            state_d.bank[free_idx] = enq_bank;
            state_d.row[free_idx]  = enq_row;
            state_d.col[free_idx]  = enq_col;
            state_d.age[free_idx]  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/sched_checker.sv
module sched_checker
    import sched_pkg::*;
#(
    parameter int NUM_ENT  = 16,
    parameter int NUM_CORE = 4,
    localparam int IDX_W   = $clog2(NUM_ENT),
    localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             bus_tick,
    input logic [NUM_CORE-1:0]              acc_ok,
    input logic [NUM_ENT-1:0]               ent_vld,
    input logic [NUM_ENT-1:0]               ent_pf,
    input logic [NUM_ENT-1:0][CORE_W-1:0]   ent_core,
    input age_t [NUM_ENT-1:0]               ent_age,
    input logic                             grant_valid,
    input logic [IDX_W-1:0]                 grant_idx
);

    logic [NUM_ENT-1:0] crit;

    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            crit[i] = ent_vld[i] && (!ent_pf[i] || acc_ok[ent_core[i]]);
        end
    end

    assert_quiet_no_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_tick || ent_vld == '0) |-> !grant_valid);

    assert_grant_live_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ent_vld[grant_idx]);

    assert_no_regrant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !(grant_valid && grant_idx == $past(grant_idx)));

    assert_crit_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && (|crit)) |-> crit[grant_idx]);

    assert_one_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(ent_vld) <= $past($countones(ent_vld)) + 1));

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_sat
        assert_age_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_vld[g] && ent_age[g] == age_t'(AGE_MAX)) |=>
            (!ent_vld[g] || ent_age[g] == age_t'(AGE_MAX)));
    end

endmodule

bind acc_aware_sched sched_checker #(
    .NUM_ENT  (NUM_ENT),
    .NUM_CORE (NUM_CORE)
) u_sched_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_tick    (bus_tick),
    .acc_ok      (acc_ok),
    .ent_vld     (ent_vld),
    .ent_pf      (ent_pf),
    .ent_core    (ent_core),
    .ent_age     (ent_age),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx)
);

// File: tb/test_acc_aware_sched.sv
module test_acc_aware_sched;

    localparam int N    = 16;
    localparam int NC   = 4;
    localparam int NB   = 8;
    localparam int RW   = 14;
    localparam int CW   = 7;
    localparam int AMAX = 255;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enq_valid = 1'b0;
    logic          enq_is_pref = 1'b0;
    logic [1:0]    enq_core = '0;
    logic [2:0]    enq_bank = '0;
    logic [RW-1:0] enq_row = '0;
    logic [CW-1:0] enq_col = '0;
    logic [NC-1:0] acc_ok = '1;
    logic [NB-1:0] open_vld = '0;
    logic [NB*RW-1:0] open_row = '0;
    logic          bus_tick = 1'b0;
    logic          grant_valid;
    logic [3:0]    grant_idx;

    acc_aware_sched i_acc_aware_sched (
        .clk, .rst_n, .enq_valid, .enq_is_pref, .enq_core, .enq_bank,
        .enq_row, .enq_col, .acc_ok, .open_vld, .open_row, .bus_tick,
        .grant_valid, .grant_idx
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";

    int m_vld [N];
    int m_pf  [N];
    int m_core[N];
    int m_bank[N];
    int m_row [N];
    int m_col [N];
    int m_age [N];

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (%s): run did not end, actual=hung expected=done", cur_req);
        summary();
    end

    // One clock: check the grant against the model at the falling edge, then advance the model.
    task automatic step();
        int best, bkey, key, free_i, any_m;
        int mm [N];
        bit c, u, rh, exp_gv;
        @(negedge clk);
        best = -1;
        bkey = -1;
        for (int i = 0; i < N; i++) begin
            if (m_vld[i] != 0) begin
                c   = (m_pf[i] == 0) || acc_ok[m_core[i]];
                u   = (m_pf[i] == 0) && !acc_ok[m_core[i]];
                rh  = open_vld[m_bank[i]] && (int'(open_row[m_bank[i]*RW +: RW]) == m_row[i]);
                key = int'(c) * 2048 + int'(rh) * 1024 + int'(u) * 512 + m_age[i];
                if (key > bkey) begin
                    bkey = key;
                    best = i;
                end
            end
        end
        exp_gv = bus_tick && (best >= 0);
        n_checks++;
        if (grant_valid !== exp_gv || (exp_gv && int'(grant_idx) != best)) begin
            n_fail++;
            $display("FAIL %s: grant valid=%0b idx=%0d, expected valid=%0b idx=%0d",
                     cur_req, grant_valid, grant_idx, exp_gv, best);
        end
        free_i = -1;
        any_m  = 0;
        for (int i = 0; i < N; i++) begin
            mm[i] = (m_vld[i] != 0 && m_pf[i] != 0 && m_bank[i] == int'(enq_bank) &&
                     m_row[i] == int'(enq_row) && m_col[i] == int'(enq_col)) ? 1 : 0;
            if (mm[i] != 0) any_m = 1;
            if (m_vld[i] == 0 && free_i < 0) free_i = i;
        end
        for (int i = 0; i < N; i++) begin
            if (m_vld[i] != 0 && m_age[i] < AMAX) m_age[i]++;
        end
        if (exp_gv) m_vld[best] = 0;
        if (enq_valid) begin
            if (!enq_is_pref && any_m != 0) begin
                for (int i = 0; i < N; i++) if (mm[i] != 0) m_pf[i] = 0;
            end else if (free_i >= 0) begin
                m_vld[free_i]  = 1;
                m_pf[free_i]   = int'(enq_is_pref);
                m_core[free_i] = int'(enq_core);
                m_bank[free_i] = int'(enq_bank);
                m_row[free_i]  = int'(enq_row);
                m_col[free_i]  = int'(enq_col);
                m_age[free_i]  = 0;
            end
        end
        @(posedge clk);
        #1;
        enq_valid = 1'b0;
        bus_tick  = 1'b0;
    endtask

    task automatic put(input bit pf, input int core, input int bank, input int row, input int col);
        enq_valid   = 1'b1;
        enq_is_pref = pf;
        enq_core    = 2'(core);
        enq_bank    = 3'(bank);
        enq_row     = RW'(row);
        enq_col     = CW'(col);
        step();
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            bus_tick = 1'b1;
            step();
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic set_open(input int bank, input bit v, input int row);
        open_vld[bank]            = v;
        open_row[bank*RW +: RW]   = RW'(row);
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_vld[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: nothing is granted before and after reset release
        cur_req = "R1";
        n_checks++;
        if (grant_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: grant_valid=%0b during reset, expected 0", grant_valid);
        end
        rst_n = 1'b1;
        tick(2);

        // R2 and R3: fill four slots with no tick, nothing may be granted
        cur_req = "R3";
        put(0, 0, 0, 5, 1);
        put(0, 1, 1, 5, 2);
        put(1, 2, 2, 5, 3);
        put(0, 3, 3, 5, 4);
        idle(3);
        // R7: equal flags, drain oldest first (slots 0,1,2,3 per R2)
        cur_req = "R7";
        tick(5);

        // R4: the low-accuracy prefetch is older and a row hit, but loses to a critical prefetch
        cur_req = "R4";
        acc_ok = 4'b0001;
        set_open(1, 1'b1, 9);
        put(1, 1, 1, 9, 0);
        put(1, 0, 2, 3, 0);
        idle(2);
        tick(3);

        // R5: a younger row hit beats an older miss; a closed bank with the same row number gives no hit
        cur_req = "R5";
        acc_ok = 4'b1111;
        set_open(4, 1'b0, 7);
        set_open(5, 1'b1, 7);
        put(0, 0, 4, 7, 0);
        put(0, 0, 6, 7, 0);
        put(0, 0, 5, 7, 0);
        idle(1);
        tick(4);

        // R6: an urgent demand beats an older accurate prefetch on equal C and RH
        cur_req = "R6";
        acc_ok = 4'b1011;
        put(1, 0, 0, 11, 0);
        put(0, 2, 3, 12, 0);
        put(0, 1, 3, 13, 0);
        idle(1);
        tick(4);

        // R8: one entry, two ticks: the second tick grants nothing
        cur_req = "R8";
        put(0, 1, 2, 1, 1);
        tick(2);

        // R9: a demand to the same line promotes the pending prefetch and fills no slot
        cur_req = "R9";
        acc_ok = 4'b1101;
        put(1, 1, 6, 20, 3);
        put(1, 0, 6, 21, 0);
        put(0, 3, 6, 20, 3);
        put(1, 0, 6, 22, 0);
        idle(1);
        tick(2);
        acc_ok = 4'b0000;
        tick(3);

        // R10: fill every slot, then offer one more demand, which must be discarded
        cur_req = "R10";
        acc_ok = 4'b1111;
        for (int i = 0; i < N; i++) put(0, i % NC, i % NB, 30, i);
        put(0, 0, 7, 31, 100);
        idle(1);
        tick(N + 2);

        // R11: refill slot 0 behind older entries, then saturate ages: the tie goes to slot 0
        cur_req = "R11";
        put(0, 0, 0, 40, 0);
        put(0, 0, 1, 40, 0);
        put(0, 0, 2, 40, 0);
        tick(1);
        put(0, 0, 3, 40, 0);
        idle(AMAX + 20);
        tick(4);

        // R2: random mix with a narrow address space so hits and merges are common
        cur_req = "R2";
        for (int k = 0; k < 3000; k++) begin
            if (k % 50 == 0) acc_ok = NC'($urandom);
            if (k % 7 == 0) begin
                set_open($urandom_range(0, 1), 1'($urandom), $urandom_range(0, 1));
            end
            enq_valid   = ($urandom_range(0, 99) < 55);
            enq_is_pref = 1'($urandom);
            enq_core    = 2'($urandom);
            enq_bank    = 3'($urandom_range(0, 1));
            enq_row     = RW'($urandom_range(0, 1));
            enq_col     = CW'($urandom_range(0, 1));
            bus_tick    = ($urandom_range(0, 99) < 40);
            step();
        end
        summary();
    end

endmodule